// File: doc/BRIEF.md
# Byte-Lane Parity Checker and Generator

This block watches a 36-bit data path split into four 9-bit lanes, where the top bit of every lane carries parity. On the incoming bus it tests each lane that the current bus width actually uses against a single odd/even parity select. It raises an active-low error flag, registered on the clock, when any such lane is wrong.

On the outgoing read path it can overwrite the top bit of each lane with freshly generated parity of the same type. When generation is off, read data passes through untouched.

The lane parity trees that do the checking are also borrowed to generate parity for mailbox reads. While such a mailbox read with generation is set up, the trees no longer look at the bus, so the error flag is held inactive. A surrounding port controller supplies the lane-use mask derived from its bus-size setting and the mailbox-read indication. It consumes the flag and the read data.

Top module: `lane_parity_unit`

## Requirements
- R1: Lane k (k = 0..3) occupies bits 9k to 9k+8; bit 9k+8 is that lane's parity bit and bits 9k to 9k+7 are its data.
- R2: With `odd_sel` = 1 a lane passes when its nine bits hold an odd number of ones; with `odd_sel` = 0 it passes when they hold an even number. The same select governs generation.
- R3: `err_n` is registered: one clock after the inputs are applied it is 0 if any lane with its `lane_use` bit set fails parity on `bus_in`, and 1 otherwise.
- R4: A lane whose `lane_use` bit is 0 never pulls `err_n` low, whatever its bits are; with `lane_use` = 0000 the flag is 1 on the next clock.
- R5: With `gen_en` = 1, `rd_data_out` equals `rd_data_in` except that bit 9k+8 of every lane is replaced by the parity bit that makes that lane satisfy R2. This holds both for mailbox reads and for other reads.
- R6: With `gen_en` = 0, `rd_data_out` equals `rd_data_in` bit for bit.
- R7: When `gen_en` = 1 and `mbox_rd` = 1, `err_n` is 1 on the next clock regardless of `bus_in` and `lane_use`.
- R8: While `rst_n` is 0 and on the first clock after its release, `err_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_in | input | 36 | Incoming bus word to be checked |
| rd_data_in | input | 36 | Read data before parity generation |
| odd_sel | input | 1 | Parity type: 1 odd, 0 even |
| gen_en | input | 1 | Enable parity generation on reads |
| lane_use | input | 4 | Per-lane mask of lanes used by the bus size |
| mbox_rd | input | 1 | Current read targets the mailbox |
| err_n | output | 1 | Registered parity error flag, active low |
| rd_data_out | output | 36 | Read data with optional generated parity |

## Verification
The assertions check four properties on every cycle. Generated lanes always satisfy the selected parity, disabled generation is a pure pass-through, and the flag stays high after a mailbox read with generation or an all-zero lane mask. Whether a single bad lane among several valid ones, especially the top lane, actually pulls the flag low with the right one-cycle latency is shown only by the bench's reference model. The same holds for the effect of flipping the parity type between cycles and for the reset value.

// File: rtl/lpu_pkg.sv
package lpu_pkg;
    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int BUS_W  = LANES * LANE_W;

    typedef struct packed {
        logic err_n;
    } lpu_state_t;
endpackage

// File: rtl/lpu_lane_tree.sv
module lpu_lane_tree #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data,
    output logic              xor_out
);
    always_comb begin
        xor_out = 1'b0;
        for (int b = 0; b < DATA_W; b++) begin
            xor_out = xor_out ^ data[b];
        end
    end
endmodule

// File: rtl/lpu_lane_gen.sv
module lpu_lane_gen #(
    parameter int LANE_W = 9
) (
    input  logic [LANE_W-1:0] lane_in,
    input  logic              tree_bit,
    input  logic              odd_sel,
    input  logic              gen_en,
    output logic [LANE_W-1:0] lane_out
);
    logic par_bit;
    always_comb begin
        par_bit  = tree_bit ^ odd_sel;
        lane_out = gen_en ? {par_bit, lane_in[LANE_W-2:0]} : lane_in;
    end
endmodule

// File: rtl/lane_parity_unit.sv
module lane_parity_unit
    import lpu_pkg::*;
#(
    parameter int NLANES = LANES,
    parameter int LW     = LANE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NLANES*LW-1:0] bus_in,
    input  logic [NLANES*LW-1:0] rd_data_in,
    input  logic                 odd_sel,
    input  logic                 gen_en,
    input  logic [NLANES-1:0]    lane_use,
    input  logic                 mbox_rd,
    output logic                 err_n,
    output logic [NLANES*LW-1:0] rd_data_out
);
    localparam int W  = NLANES * LW;
    localparam int DW = LW - 1;

    logic              share_gen;
    logic [W-1:0]      shared_src;
    logic [NLANES-1:0] sh_x;
    logic [NLANES-1:0] rd_x;
    logic [NLANES-1:0] chk_fail;
    lpu_state_t        st_d, st_q;

    assign share_gen  = gen_en & mbox_rd;
    assign shared_src = share_gen ? rd_data_in : bus_in;

    for (genvar k = 0; k < NLANES; k++) begin : g_lane
        lpu_lane_tree #(.DATA_W(DW)) shared_tree_i (
            .data    (shared_src[k*LW +: DW]),
            .xor_out (sh_x[k])
        );
        lpu_lane_tree #(.DATA_W(DW)) read_tree_i (
            .data    (rd_data_in[k*LW +: DW]),
            .xor_out (rd_x[k])
        );
        assign chk_fail[k] = (sh_x[k] ^ shared_src[k*LW + DW]) != odd_sel;

        lpu_lane_gen #(.LANE_W(LW)) gen_i (
            .lane_in  (rd_data_in[k*LW +: LW]),
            .tree_bit (share_gen ? sh_x[k] : rd_x[k]),
            .odd_sel  (odd_sel),
            .gen_en   (gen_en),
            .lane_out (rd_data_out[k*LW +: LW])
        );

        assert_gen_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
            gen_en |-> ((^rd_data_out[k*LW +: LW]) == odd_sel));
    end

    always_comb begin
        st_d = st_q;
        if (share_gen) begin
            st_d.err_n = 1'b1;
        end else begin
            st_d.err_n = ~|(chk_fail & lane_use);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.err_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign err_n = st_q.err_n;

    assert_forced_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_en && mbox_rd) |=> err_n);

    assert_unused_lanes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_use == '0) |=> err_n);

    assert_passthru_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_en |-> (rd_data_out == rd_data_in));
endmodule

// File: tb/lane_parity_unit_tb.sv
module lane_parity_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [35:0] bus_in = '0;
    logic [35:0] rd_data_in = '0;
    logic        odd_sel = 1'b0;
    logic        gen_en = 1'b0;
    logic [3:0]  lane_use = '0;
    logic        mbox_rd = 1'b0;
    logic        err_n;
    logic [35:0] rd_data_out;

    int checks = 0;
    int errors = 0;
    bit exp_err = 1'b1;
    string err_tag = "R8";
    bit finished = 1'b0;

    lane_parity_unit dut_i (
        .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .rd_data_in(rd_data_in),
        .odd_sel(odd_sel), .gen_en(gen_en), .lane_use(lane_use),
        .mbox_rd(mbox_rd), .err_n(err_n), .rd_data_out(rd_data_out)
    );

    always #10 clk = ~clk;

    function automatic int ones9(input logic [35:0] w, input int k);
        int n = 0;
        for (int b = 0; b < 9; b++) if (w[k*9+b]) n++;
        return n;
    endfunction

    function automatic bit model_err(input logic [35:0] w, input logic [3:0] use_m,
                                     input bit odd, input bit gen, input bit mb);
        bit ok = 1'b1;
        if (gen && mb) return 1'b1;
        for (int k = 0; k < 4; k++) begin
            if (use_m[k] && ((ones9(w, k) % 2) != (odd ? 1 : 0))) ok = 1'b0;
        end
        return ok;
    endfunction

    function automatic logic [35:0] model_rd(input logic [35:0] r, input bit odd, input bit gen);
        logic [35:0] o = r;
        if (!gen) return r;
        for (int k = 0; k < 4; k++) begin
            o[k*9+8] = 1'b0;
            if ((ones9(o, k) % 2) != (odd ? 1 : 0)) o[k*9+8] = 1'b1;
        end
        return o;
    endfunction

    task automatic check_now(input string rd_tag);
        logic [35:0] er;
        checks++;
        if (err_n !== exp_err) begin
            errors++;
            $display("FAIL %s err_n actual %0b expected %0b", err_tag, err_n, exp_err);
        end
        er = model_rd(rd_data_in, odd_sel, gen_en);
        checks++;
        if (rd_data_out !== er) begin
            errors++;
            $display("FAIL %s rd_data_out actual %h expected %h", rd_tag, rd_data_out, er);
        end
    endtask

    // Apply at a falling edge; registered flag is checked at the next falling edge.
    task automatic step(input logic [35:0] b, input logic [35:0] r, input bit odd,
                        input bit gen, input logic [3:0] u, input bit mb, input string tag);
        bus_in = b; rd_data_in = r; odd_sel = odd; gen_en = gen; lane_use = u; mbox_rd = mb;
        #1;
        check_now(gen ? "R5" : "R6");
        @(posedge clk);
        exp_err = model_err(b, u, odd, gen, mb);
        err_tag = tag;
        @(negedge clk);
        check_now(gen ? "R5" : "R6");
    endtask

    function automatic string auto_tag(input logic [3:0] u, input bit gen, input bit mb);
        if (gen && mb) return "R7";
        if (u == 4'b0000) return "R4";
        return "R3";
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        check_now("R6");                       // R8 flag high in reset
        rst_n = 1'b1;
        @(negedge clk);
        check_now("R6");                       // R8 first cycle after reset
        // even parity, all clean
        step(36'h0, 36'h0, 1'b0, 1'b0, 4'hF, 1'b0, "R2");
        // odd select on all-zero lanes: every lane fails
        step(36'h0, 36'h0, 1'b1, 1'b0, 4'hF, 1'b0, "R2");
        // R1: only top lane bad (single data bit 27 set, even parity)
        step(36'h0_0800_0000, 36'h0, 1'b0, 1'b0, 4'hF, 1'b0, "R1");
        // R1: fix lane 3 with its parity bit 35
        step(36'h8_0800_0000, 36'h0, 1'b0, 1'b0, 4'hF, 1'b0, "R1");
        // R4: bad lane 3 masked out
        step(36'h0_0800_0000, 36'h0, 1'b0, 1'b0, 4'h7, 1'b0, "R4");
        step(36'hF_FFFF_FFFF, 36'h0, 1'b1, 1'b0, 4'h0, 1'b0, "R4");
        // R3: bad lane 0 with byte-size mask
        step(36'h0_0000_0001, 36'h0, 1'b0, 1'b0, 4'h1, 1'b0, "R3");
        // R5 generation, normal read
        step(36'h0, 36'h1_2345_6789, 1'b1, 1'b1, 4'hF, 1'b0, "R2");
        // R7: mailbox read with generation, bus garbage
        step(36'h0_0000_0001, 36'hA_BCDE_F012, 1'b0, 1'b1, 4'hF, 1'b1, "R7");
        // mailbox read without generation: checking active
        step(36'h0_0000_0001, 36'hA_BCDE_F012, 1'b0, 1'b0, 4'hF, 1'b1, "R3");
        for (int i = 0; i < 400; i++) begin
            logic [35:0] b, r;
            logic [3:0] u;
            bit o, g, m;
            b = {$urandom, $urandom} ; r = {$urandom, $urandom};
            u = 4'($urandom); o = 1'($urandom); g = 1'($urandom); m = 1'($urandom);
            step(b, r, o, g, u, m, auto_tag(u, g, m));
        end
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule